// File: doc/BRIEF.md
# Translation Unit Control and Fault Interrupt Registers

This block is the register file that sits beside a small I/O address translation unit. Software uses it to reset the unit, pick an idle policy, turn on translation, table walking and TLB emulation, and give the walker the physical base of its translation table. The translation logic reports faults on a five-bit event input together with the device address that faulted. The block records each event in a sticky status register, keeps the last faulting address, and raises one interrupt line when an enabled status bit is set.

Software acknowledges a fault by writing the status value it read back to the status register, which clears the bits written as one. A soft reset, requested through the configuration register, puts every register back to its default value. It then holds the block for a fixed number of cycles, and a reset-done bit reports when that hold is over. The bus uses word addresses 0 to 7 with a single-cycle write strobe and combinational read data.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: Address 0 reads the revision: major number in bits 7:4 and minor number in bits 3:0 (parameters, default 1 and 1). All other bits read 0.
- R2: Address 1 is the configuration register. Bits 4:3 hold the idle mode (0 force, 1 none, 2 smart), bit 0 holds auto-idle, and both drive their outputs. Bit 1 is the soft-reset request and always reads 0.
- R3: Writing 1 to bit 1 of address 1 returns every register to its default. Bit 0 of address 2 (reset-done) then reads 0 for RST_CYCLES cycles and afterwards reads 1. Bus writes and fault events during that time have no effect.
- R4: Address 5 is the control register: bit 1 drives mmu_en, bit 2 drives walk_en and bit 3 drives emu_en. Other bits read 0.
- R5: Address 6 holds the table base. Bits below ALIGN_BITS (default 14, a 16 KB alignment) are forced to 0, and the stored value drives table_base.
- R6: Address 3 is the fault status register, with bit 0 TLB miss, bit 1 translation fault, bit 2 emulation miss, bit 3 table-walk fault and bit 4 multi-hit. A fault_evt bit that is high on a clock edge sets the matching status bit whether or not that bit is enabled.
- R7: Writing to address 3 clears each status bit written as 1 and leaves the others unchanged. A fault event on the same edge takes precedence over the clear.
- R8: Address 4 is the interrupt enable register, with the same bit layout as address 3. Its default is 0x1E, so TLB miss is disabled.
- R9: irq is high exactly when the status register ANDed with the enable register is nonzero. It changes on the edge after the event or the write.
- R10: On every edge where fault_evt is nonzero, fault_addr is captured into address 7, which keeps that value until the next event or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high with bus_sel |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| fault_evt | input | 5 | Fault event pulses from translation logic |
| fault_addr | input | 32 | Faulting device address |
| irq | output | 1 | Fault interrupt |
| mmu_en | output | 1 | Translation enable |
| walk_en | output | 1 | Table walker enable |
| emu_en | output | 1 | TLB emulation enable |
| idle_mode | output | 2 | Idle policy |
| auto_idle | output | 1 | Auto-idle enable |
| table_base | output | 32 | Translation table base |

## Verification
The hardest case to reach from the ports is the collision on the status register, where a clearing write and a new fault event hit the same bit on the same edge. The bench drives both at once on one negative edge and checks that the bit survives while a bit that was only cleared drops. The interplay of status and enable is covered by a sweep of all 32 enable values against all 32 event patterns, each followed by a partial acknowledge. Writes and fault pulses are also issued during the soft-reset hold to confirm they are dropped.

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs #(
  parameter int          RST_CYCLES  = 4,
  parameter logic [3:0]  REV_MAJOR   = 4'd1,
  parameter logic [3:0]  REV_MINOR   = 4'd1,
  parameter int          ALIGN_BITS  = 14,
  parameter logic [4:0]  IRQ_EN_INIT = 5'h1E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [4:0]  fault_evt,
  input  logic [31:0] fault_addr,
  output logic        irq,
  output logic        mmu_en,
  output logic        walk_en,
  output logic        emu_en,
  output logic [1:0]  idle_mode,
  output logic        auto_idle,
  output logic [31:0] table_base
);

  localparam int          CNT_W      = $clog2(RST_CYCLES + 1);
  localparam logic [31:0] ALIGN_MASK = (32'd1 << ALIGN_BITS) - 32'd1;
  localparam logic [2:0]  A_REV = 3'd0, A_CFG = 3'd1, A_STS = 3'd2, A_ISTAT = 3'd3,
                          A_IEN = 3'd4, A_CTRL = 3'd5, A_TBASE = 3'd6, A_FADDR = 3'd7;

  logic             rst_busy;
  logic [CNT_W-1:0] rst_cnt;
  logic [4:0]       irq_stat, irq_en;
  logic [2:0]       ctrl_q;
  logic [31:0]      fault_q;
  logic             wr, srst_req;

  assign wr       = bus_sel & bus_we & ~rst_busy;
  assign srst_req = wr && (bus_addr == A_CFG) && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_busy   <= 1'b0;
      rst_cnt    <= '0;
      idle_mode  <= 2'd0;
      auto_idle  <= 1'b0;
      irq_stat   <= '0;
      irq_en     <= IRQ_EN_INIT;
      ctrl_q     <= '0;
      table_base <= '0;
      fault_q    <= '0;
    end else if (srst_req) begin
      rst_busy   <= 1'b1;
      rst_cnt    <= CNT_W'(RST_CYCLES);
      idle_mode  <= 2'd0;
      auto_idle  <= 1'b0;
      irq_stat   <= '0;
      irq_en     <= IRQ_EN_INIT;
      ctrl_q     <= '0;
      table_base <= '0;
      fault_q    <= '0;
    end else if (rst_busy) begin
      if (rst_cnt <= CNT_W'(1)) rst_busy <= 1'b0;
      rst_cnt <= rst_cnt - 1'b1;
    end else begin
      if (wr) begin
        case (bus_addr)
          A_CFG: begin
            idle_mode <= bus_wdata[4:3];
            auto_idle <= bus_wdata[0];
          end
          A_IEN:   irq_en     <= bus_wdata[4:0];
          A_CTRL:  ctrl_q     <= bus_wdata[3:1];
          A_TBASE: table_base <= bus_wdata & ~ALIGN_MASK;
          default: ;
        endcase
      end
      irq_stat <= (irq_stat & ~((wr && bus_addr == A_ISTAT) ? bus_wdata[4:0] : 5'd0))
                  | fault_evt;
      if (|fault_evt) fault_q <= fault_addr;
    end
  end

  always_comb begin
    case (bus_addr)
      A_REV:   bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
      A_CFG:   bus_rdata = {27'd0, idle_mode, 2'b00, auto_idle};
      A_STS:   bus_rdata = {31'd0, ~rst_busy};
      A_ISTAT: bus_rdata = {27'd0, irq_stat};
      A_IEN:   bus_rdata = {27'd0, irq_en};
      A_CTRL:  bus_rdata = {28'd0, ctrl_q, 1'b0};
      A_TBASE: bus_rdata = table_base;
      A_FADDR: bus_rdata = fault_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = |(irq_stat & irq_en);
  assign mmu_en  = ctrl_q[0];
  assign walk_en = ctrl_q[1];
  assign emu_en  = ctrl_q[2];

endmodule

module xlat_ctrl_regs_chk #(
  parameter int ALIGN_BITS = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [4:0]  fault_evt,
  input logic [31:0] fault_addr,
  input logic        irq,
  input logic        mmu_en,
  input logic        walk_en,
  input logic        emu_en,
  input logic [31:0] table_base,
  input logic        busy,
  input logic [4:0]  stat,
  input logic [31:0] fault_q
);

  logic live_wr;
  assign live_wr = bus_sel && bus_we && !busy;

  assert_srst_defaults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && bus_addr == 3'd1 && bus_wdata[1])
      |=> (busy && !mmu_en && !walk_en && !emu_en && table_base == 32'd0 && stat == 5'd0));

  assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && bus_addr == 3'd5)
      |=> (mmu_en == $past(bus_wdata[1]) && walk_en == $past(bus_wdata[2])
           && emu_en == $past(bus_wdata[3])));

  assert_tbase_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && bus_addr == 3'd6)
      |=> (table_base[31:ALIGN_BITS] == $past(bus_wdata[31:ALIGN_BITS])
           && table_base[ALIGN_BITS-1:0] == '0));

  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fault_evt != 5'd0) |=> ((stat & $past(fault_evt)) == $past(fault_evt)));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(fault_evt) != 5'd0
                    || $past(bus_sel && bus_we && bus_addr == 3'd4)));

  assert_addr_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fault_evt != 5'd0 && !(live_wr && bus_addr == 3'd1 && bus_wdata[1]))
      |=> (fault_q == $past(fault_addr)));

endmodule

bind xlat_ctrl_regs xlat_ctrl_regs_chk #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .fault_evt(fault_evt), .fault_addr(fault_addr), .irq(irq),
  .mmu_en(mmu_en), .walk_en(walk_en), .emu_en(emu_en), .table_base(table_base),
  .busy(rst_busy), .stat(irq_stat), .fault_q(fault_q)
);

// File: tb/xlat_ctrl_regs_tb.sv
module xlat_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  fault_evt = '0;
  logic [31:0] fault_addr = '0;
  logic        irq, mmu_en, walk_en, emu_en, auto_idle;
  logic [1:0]  idle_mode;
  logic [31:0] table_base;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_ctrl_regs #(.RST_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_evt(fault_evt),
    .fault_addr(fault_addr), .irq(irq), .mmu_en(mmu_en), .walk_en(walk_en),
    .emu_en(emu_en), .idle_mode(idle_mode), .auto_idle(auto_idle), .table_base(table_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] p, input logic [31:0] fa);
    @(negedge clk);
    fault_evt = p; fault_addr = fa;
    @(posedge clk);
    @(negedge clk);
    fault_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_fa;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd0, v); check("R1 revision", v, 32'h11);
    rd(3'd1, v); check("R2 config default", v, 32'h0);
    rd(3'd2, v); check("R3 reset-done after power-on", v, 32'h1);
    rd(3'd3, v); check("R6 status default", v, 32'h0);
    rd(3'd4, v); check("R8 enable default", v, 32'h1E);
    rd(3'd5, v); check("R4 control default", v, 32'h0);
    rd(3'd6, v); check("R5 base default", v, 32'h0);
    rd(3'd7, v); check("R10 fault addr default", v, 32'h0);
    check("R9 irq default", {31'd0, irq}, 32'd0);

    // configuration sweep
    for (int m = 0; m < 4; m++)
      for (int ai = 0; ai < 2; ai++) begin
        wr(3'd1, 32'hFFFF_FFE4 | (m << 3) | ai);
        rd(3'd1, v);
        check("R2 config readback", v, (m << 3) | ai);
        check("R2 idle/auto outputs", {29'd0, idle_mode, auto_idle}, (m << 1) | ai);
      end

    // control sweep
    for (int c = 0; c < 16; c++) begin
      wr(3'd5, 32'hFFFF_FFF0 | c);
      rd(3'd5, v);
      check("R4 control readback", v, c & 32'hE);
      check("R4 control outputs", {29'd0, emu_en, walk_en, mmu_en}, (c >> 1) & 7);
    end

    // table base
    for (int k = 0; k < 8; k++) begin
      v = 32'h8765_4321 ^ (32'h1111_1111 * k) ^ (32'h3FFF >> k);
      wr(3'd6, v);
      check("R5 base output", table_base, v & 32'hFFFF_C000);
      rd(3'd6, v); check("R5 base readback", v, table_base & 32'hFFFF_C000);
    end

    // status / enable / irq sweep
    exp_fa = 32'h0;
    for (int e = 0; e < 32; e++)
      for (int p = 0; p < 32; p++) begin
        wr(3'd4, e);
        wr(3'd3, 32'h1F);
        rd(3'd3, v); check("R7 clear all", v, 32'h0);
        pulse(p[4:0], 32'hA000_0000 | (e << 8) | p);
        if (p != 0) exp_fa = 32'hA000_0000 | (e << 8) | p;
        rd(3'd3, v); check("R6 event sets status", v, p);
        check("R9 irq after event", {31'd0, irq}, {31'd0, |(p[4:0] & e[4:0])});
        rd(3'd7, v); check("R10 fault addr", v, exp_fa);
        wr(3'd3, 32'h15);
        rd(3'd3, v); check("R7 partial clear", v, p & 32'hA);
        check("R9 irq after clear", {31'd0, irq}, {31'd0, |(p[4:0] & e[4:0] & 5'h0A)});
      end

    // enable default excludes TLB miss: restore via soft reset later; here direct check
    wr(3'd4, 32'h1E);
    wr(3'd3, 32'h1F);
    pulse(5'h01, 32'h1234_5000);
    check("R8 tlb miss not enabled", {31'd0, irq}, 32'd0);
    rd(3'd3, v); check("R6 tlb miss recorded", v, 32'h1);

    // collision: event wins over clear
    wr(3'd3, 32'h1F);
    pulse(5'h0A, 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0A;
    fault_evt = 5'h02; fault_addr = 32'h5555_0000;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; fault_evt = '0;
    rd(3'd3, v); check("R7 set wins over clear", v, 32'h02);

    // soft reset and reset-done timing
    wr(3'd5, 32'hE); wr(3'd6, 32'hFFFF_FFFF); wr(3'd4, 32'h1F); wr(3'd1, 32'h19);
    pulse(5'h10, 32'hCAFE_0000);
    wr(3'd1, 32'h02);
    n = 0;
    rd(3'd2, v);
    while (v[0] == 1'b0 && n < 100) begin
      n++;
      @(negedge clk);
      rd(3'd2, v);
    end
    check("R3 reset-done low cycles", n, RST_CYC);
    rd(3'd1, v); check("R3 config after soft reset", v, 32'h0);
    rd(3'd3, v); check("R3 status after soft reset", v, 32'h0);
    rd(3'd4, v); check("R3 enable after soft reset", v, 32'h1E);
    rd(3'd5, v); check("R3 control after soft reset", v, 32'h0);
    rd(3'd6, v); check("R3 base after soft reset", v, 32'h0);
    rd(3'd7, v); check("R3 fault addr after soft reset", v, 32'h0);
    check("R3 outputs after soft reset", {26'd0, irq, mmu_en, walk_en, emu_en, idle_mode},
          32'd0);

    // writes and events ignored while resetting
    wr(3'd1, 32'h02);
    wr(3'd5, 32'hE);
    pulse(5'h1F, 32'hDEAD_0000);
    repeat (RST_CYC + 2) @(negedge clk);
    rd(3'd5, v); check("R3 write ignored during reset", v, 32'h0);
    rd(3'd3, v); check("R3 event ignored during reset", v, 32'h0);
    rd(3'd7, v); check("R3 address ignored during reset", v, 32'h0);
    rd(3'd2, v); check("R3 reset-done returns", v, 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule